// File: doc/BRIEF.md
# Wakeup Interrupt Sense Converter

This block conditions a bank of peripheral interrupt lines for a downstream interrupt controller that only accepts active-high levels or rising edges. Each line is synchronised into the block clock and then reshaped according to a 3-bit sense code. An active-low level is inverted. A falling edge becomes a one-cycle high pulse, and so does a rising edge or either transition in dual-edge mode. An active-high level passes straight through. Each line also has an enable bit that gates its output.

Software sets the block up through a small word-addressed register port. One window holds the packed enable bits. A second window holds one configuration word per line. Reads are combinational and writes take effect on the clock edge. The number of lines is a parameter, 168 by default.

Top module: `wake_sense_conv`

## Requirements
- R1: After reset every enable bit and every configuration code is 0, and every output is low.
- R2: Enable bits sit in 32-bit words starting at byte offset 0x10, with line n in word n/32 at bit n%32. A write replaces only the addressed word and leaves the other words unchanged. Bits above the last line read as 0, so the top word reads 0x000000FF with 168 lines.
- R3: Line n has a configuration word at byte offset 0x110 + 4*n. Only bits [2:0] are stored, and bits [31:3] read as 0.
- R4: Any other offset, or any offset whose low two bits are nonzero, reads 0. A write to such an offset changes nothing.
- R5: Code 3'b000 (active-low level) drives the output high while the synchronised input is low.
- R6: Code 3'b100 (active-high level) drives the output equal to the synchronised input.
- R7: Code 3'b110 (rising edge) gives a single-cycle high pulse for each low-to-high input transition.
- R8: Code 3'b010 (falling edge) gives a single-cycle high pulse for each high-to-low input transition.
- R9: Code 3'b111 (dual edge) gives a single-cycle high pulse for each transition in either direction.
- R10: A line whose enable bit is 0 has a low output. Its edge history keeps tracking the input, so setting the enable bit never produces a pulse for an input change that happened while the line was disabled.
- R11: Codes 3'b001, 3'b011 and 3'b101 hold the output low.
- R12: Inputs pass two synchroniser flops. A level change applied before clock edge k appears on the output after edge k+2.
- R13: An enable or configuration write registered at edge e governs the output computed at edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_in | input | 168 | Raw peripheral interrupt lines |
| irq_out | output | 168 | Normalised interrupt lines |

## Verification
Two things can land on the same clock edge: a register write that changes a line's enable or sense code, and a synchronised input transition reaching that line's edge detector. The random phase toggles sparse input bits every cycle while about a third of the cycles carry an enable or configuration write. This makes writes and edges coincide often. A cycle-level reference model built from the requirements judges the whole output vector at every cycle. It applies the register update at the edge and the new setting one edge later.

// File: rtl/wake_sense_conv.sv
module wake_sense_conv #(
  parameter int LINES    = 168,
  parameter int ADDR_W   = 12,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic [LINES-1:0]  irq_out
);
  localparam int EN_WORDS = (LINES + 31) / 32;
  localparam int EW_W     = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int LN_W     = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int WI_W     = ADDR_W - 2;

  localparam logic [2:0] C_LVL_LO = 3'b000;
  localparam logic [2:0] C_FALL   = 3'b010;
  localparam logic [2:0] C_LVL_HI = 3'b100;
  localparam logic [2:0] C_RISE   = 3'b110;
  localparam logic [2:0] C_BOTH   = 3'b111;

  function automatic logic shape(logic [2:0] code, logic now, logic old);
    case (code)
      C_LVL_LO: shape = ~now;
      C_LVL_HI: shape = now;
      C_RISE:   shape = now & ~old;
      C_FALL:   shape = ~now & old;
      C_BOTH:   shape = now ^ old;
      default:  shape = 1'b0;
    endcase
  endfunction

  // word-aligned decode
  logic [WI_W-1:0] waddr, en_wo, cfg_wo;
  logic            aligned, en_hit, cfg_hit;
  logic [EW_W-1:0] en_word;
  logic [LN_W-1:0] cfg_line;

  assign waddr    = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign en_wo    = waddr - WI_W'(EN_BASE / 4);
  assign cfg_wo   = waddr - WI_W'(CFG_BASE / 4);
  assign en_hit   = aligned && (waddr >= WI_W'(EN_BASE / 4)) && (en_wo < WI_W'(EN_WORDS));
  assign cfg_hit  = aligned && (waddr >= WI_W'(CFG_BASE / 4)) && (cfg_wo < WI_W'(LINES));
  assign en_word  = en_wo[EW_W-1:0];
  assign cfg_line = cfg_wo[LN_W-1:0];

  logic [LINES-1:0] en_q;
  logic [2:0]       cfg_q [LINES];
  logic [31:0]      en_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (reg_we && en_hit) begin
      for (int i = 0; i < LINES; i++)
        if (en_word == EW_W'(i / 32)) en_q[i] <= reg_wdata[i % 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) cfg_q[i] <= '0;
    end else if (reg_we && cfg_hit) begin
      cfg_q[cfg_line] <= reg_wdata[2:0];
    end
  end

  always_comb begin
    en_rd = '0;
    for (int i = 0; i < LINES; i++)
      if (en_word == EW_W'(i / 32)) en_rd[i % 32] = en_q[i];
  end

  assign reg_rdata = en_hit  ? en_rd :
                     cfg_hit ? {29'b0, cfg_q[cfg_line]} : 32'b0;

  // synchroniser, history and shaped output
  logic [LINES-1:0] s1, s2, s3, sense, out_q;
  logic [LINES-1:0] is_rf, is_bad, is_lo, is_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      s3    <= '0;
      out_q <= '0;
    end else begin
      s1    <= irq_in;
      s2    <= s1;
      s3    <= s2;
      out_q <= en_q & sense;
    end
  end

  assign irq_out = out_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sense[g]  = shape(cfg_q[g], s2[g], s3[g]);
    assign is_rf[g]  = (cfg_q[g] == C_RISE) || (cfg_q[g] == C_FALL);
    assign is_lo[g]  = (cfg_q[g] == C_LVL_LO);
    assign is_hi[g]  = (cfg_q[g] == C_LVL_HI);
    assign is_bad[g] = !(is_rf[g] || is_lo[g] || is_hi[g] || cfg_q[g] == C_BOTH);

    a_r7_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(out_q[g]) && $past(is_rf[g], 2) && ($past(cfg_q[g]) == $past(cfg_q[g], 2)))
        |-> !out_q[g]);
  end

  a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q & ~$past(en_q)) == '0);

  a_r11_bad_code_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q & $past(is_bad)) == '0);

  a_r6_level_high_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q ^ $past(s2)) & $past(is_hi & en_q)) == '0);

  a_r5_level_low_invert: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q ^ ~$past(s2)) & $past(is_lo & en_q)) == '0);

  a_r12_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
    s3 == $past(s2));

endmodule

// File: tb/sim_wake_sense_conv.sv
module sim_wake_sense_conv;
  localparam int N = 168;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  irq_out;

  always #5 clk = ~clk;

  wake_sense_conv u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  // reference model built from the requirements
  logic [N-1:0] m_en, m_s1, m_s2, m_s3, m_out;
  logic [2:0]   m_cfg [N];

  function automatic logic want(logic [2:0] c, logic nw, logic od);
    case (c)
      3'b000:  return !nw;
      3'b100:  return nw;
      3'b110:  return nw && !od;
      3'b010:  return !nw && od;
      3'b111:  return nw != od;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_out <= '0;
      for (int i = 0; i < N; i++) m_cfg[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) m_out[i] <= m_en[i] && want(m_cfg[i], m_s2[i], m_s3[i]);
      m_s1 <= irq_in; m_s2 <= m_s1; m_s3 <= m_s2;
      if (reg_we && reg_addr[1:0] == 2'b00) begin
        if (int'(reg_addr) >= 'h10 && int'(reg_addr) < 'h10 + 24) begin
          for (int i = 0; i < N; i++)
            if (i / 32 == (int'(reg_addr) - 'h10) / 4) m_en[i] <= reg_wdata[i % 32];
        end else if (int'(reg_addr) >= 'h110 && int'(reg_addr) < 'h110 + 4 * N) begin
          m_cfg[(int'(reg_addr) - 'h110) / 4] <= reg_wdata[2:0];
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] v = '0;
    int ai = int'(a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (ai >= 'h10 && ai < 'h10 + 24) begin
      for (int b = 0; b < 32; b++) begin
        int ln = ((ai - 'h10) / 4) * 32 + b;
        if (ln < N) v[b] = m_en[ln];
      end
      return v;
    end
    if (ai >= 'h110 && ai < 'h110 + 4 * N) return {29'b0, m_cfg[(ai - 'h110) / 4]};
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (irq_out !== m_out) begin
        fails++;
        $display("FAIL R5 R6 R7 R8 R9 R10 R11 R12 R13 output vector: actual %h expected %h",
                 irq_out, m_out);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    tick();
    rst_n = 1'b1;
    cmp_on = 1;

    // R1 reset state
    chk("R1 outputs", 32'(irq_out != '0), 32'h0);
    rd("R1 enable word", 12'h010, 32'h0);
    rd("R1 config line0", 12'h110, 32'h0);
    rd("R1 config last", 12'h3AC, 32'h0);

    // R2 enable bank
    wr(12'h024, 32'hFFFF_FFFF);
    rd("R2 top word masked", 12'h024, 32'h0000_00FF);
    wr(12'h014, 32'hA5A5_A5A5);
    rd("R2 word1", 12'h014, 32'hA5A5_A5A5);
    rd("R2 word0 untouched", 12'h010, 32'h0);
    rd("R2 word2 untouched", 12'h018, 32'h0);
    rd("R2 word5 untouched", 12'h024, 32'h0000_00FF);

    // R3 config words
    wr(12'h12C, 32'hFFFF_FFF6);
    rd("R3 config low bits", 12'h12C, 32'h6);

    // R4 unmapped
    wr(12'h028, 32'hFFFF_FFFF);
    rd("R4 past enable bank", 12'h028, 32'h0);
    rd("R4 enable unchanged", 12'h024, 32'h0000_00FF);
    rd("R4 past config", 12'h3B0, 32'h0);
    rd("R4 offset zero", 12'h000, 32'h0);
    rd("R4 unaligned", 12'h012, 32'h0);
    wr(12'h016, 32'hFFFF_FFFF);
    rd("R4 unaligned write ignored", 12'h014, 32'hA5A5_A5A5);

    for (int w = 0; w < 6; w++) wr(12'(16 + 4 * w), 32'h0);

    // directed shaping
    wr(12'h110, 32'h4);
    wr(12'h114, 32'h0);
    wr(12'h118, 32'h6);
    wr(12'h11C, 32'h2);
    wr(12'h120, 32'h7);
    wr(12'h124, 32'h6);
    wr(12'h128, 32'h5);
    irq_in[3] = 1'b1;
    irq_in[5] = 1'b1;
    repeat (5) tick();
    wr(12'h010, 32'h5F);
    repeat (5) tick();
    chk("R5 low input gives high", 32'(irq_out[1]), 32'h1);
    chk("R10 no event on enable (line3)", 32'(irq_out[3]), 32'h0);
    chk("R6 low input gives low", 32'(irq_out[0]), 32'h0);

    irq_in[0] = 1'b1;
    tick(); chk("R12 after one edge", 32'(irq_out[0]), 32'h0);
    tick(); chk("R12 after two edges", 32'(irq_out[0]), 32'h0);
    tick(); chk("R12 R6 after three edges", 32'(irq_out[0]), 32'h1);

    irq_in[1] = 1'b1;
    repeat (3) tick();
    chk("R5 high input gives low", 32'(irq_out[1]), 32'h0);

    irq_in[2] = 1'b1;
    repeat (3) tick(); chk("R7 pulse", 32'(irq_out[2]), 32'h1);
    tick();            chk("R7 pulse ends", 32'(irq_out[2]), 32'h0);

    irq_in[3] = 1'b0;
    repeat (3) tick(); chk("R8 pulse", 32'(irq_out[3]), 32'h1);
    tick();            chk("R8 pulse ends", 32'(irq_out[3]), 32'h0);

    irq_in[4] = 1'b1;
    repeat (3) tick(); chk("R9 rise pulse", 32'(irq_out[4]), 32'h1);
    tick();            chk("R9 rise pulse ends", 32'(irq_out[4]), 32'h0);
    irq_in[4] = 1'b0;
    repeat (3) tick(); chk("R9 fall pulse", 32'(irq_out[4]), 32'h1);
    tick();            chk("R9 fall pulse ends", 32'(irq_out[4]), 32'h0);

    chk("R10 disabled line low", 32'(irq_out[5]), 32'h0);
    wr(12'h010, 32'h7F);
    for (int k = 0; k < 4; k++) begin
      chk("R10 no spurious pulse", 32'(irq_out[5]), 32'h0);
      tick();
    end
    irq_in[5] = 1'b0;
    repeat (2) tick();
    irq_in[5] = 1'b1;
    repeat (3) tick();
    chk("R10 enabled line pulses", 32'(irq_out[5]), 32'h1);

    for (int k = 0; k < 6; k++) begin
      irq_in[6] = ~irq_in[6];
      tick();
      chk("R11 undefined code low", 32'(irq_out[6]), 32'h0);
    end

    wr(12'h010, 32'h7E);
    chk("R13 old enable still used", 32'(irq_out[0]), 32'h1);
    tick();
    chk("R13 new enable applied", 32'(irq_out[0]), 32'h0);

    // random phase
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int r;
      int k;
      logic [11:0] a;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 15) == 0) irq_in[i] = ~irq_in[i];
      k = $urandom_range(0, 3);
      case (k)
        0:       a = 12'(16 + 4 * $urandom_range(0, 5));
        1, 2:    a = 12'('h110 + 4 * $urandom_range(0, N - 1));
        default: a = 12'($urandom);
      endcase
      r = $urandom_range(0, 9);
      if (r < 3) begin
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = {$urandom, 3'b000} | 32'($urandom_range(0, 7));
        if (k == 0) reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
        reg_addr = a;
        #1;
        chk("R2 R3 R4 random read", reg_rdata, m_read(a));
      end
      tick();
    end
    reg_we = 1'b0;
    repeat (4) tick();
    finish_run();
  end
endmodule